// File: doc/BRIEF.md
# SPI Slave with Daisy-Chain Forwarding

This block is the target side of a four-wire synchronous serial link. It samples the serial clock, the data input and the active-low select from the pins. Each passes through a two-flop synchronizer into a faster system clock, and edges are detected in that domain. The system clock must run at least four times faster than the serial clock. At select assertion the block takes a parallel word to send. It shifts that word out most significant bit first while it shifts the incoming bits in. When select is released, it presents the received word on a parallel output with a one-cycle valid strobe.

Clock polarity and phase are selected by two configuration inputs, so all four common modes are covered. A chain input makes the block behave as one stage of a daisy chain. The shift register then keeps running, so that each later group of bits on the output is an exact copy of the group received just before it. A policy input selects what happens when the master sends more clocks than one word needs.

The data output enable models the pad's high-impedance state. Pads, register maps and command decoding belong to the surrounding logic.

Top module: `spi_chain_slave`

## Requirements
- R1: While select (`spi_csn`) is high, `spi_miso_oe` is 0 and `spi_miso` is 0. Serial clock and data toggles produce no `sel_start`, `rx_valid` or `frame_err` pulse.
- R2: `cfg_cpol` gives the idle clock level. With `cfg_cpha`=0 data is sampled on the first (leading) clock edge of each bit and launched on the trailing edge. With `cfg_cpha`=1 it is launched on the leading edge and sampled on the trailing edge. Bits travel most significant first in both directions. In an exact WORD_W-bit transfer, the bits on `spi_miso` equal `tx_word`, and the bits sampled from `spi_mosi` form `rx_word`.
- R3: Each falling edge of `spi_csn` produces exactly one single-cycle `sel_start` pulse, even when no clocks follow.
- R4: `rx_word` changes only in a cycle where `rx_valid` is 1. `rx_valid` is a single-cycle pulse issued after `spi_csn` rises. With `cfg_chain`=0, an exact WORD_W-bit transfer always produces it.
- R5: With `cfg_chain`=0 and `cfg_strict`=1, a transfer with more than WORD_W sample edges produces no `rx_valid`, and `rx_word` keeps its previous value.
- R6: With `cfg_chain`=0 and `cfg_strict`=0, a transfer with more than WORD_W sample edges still produces `rx_valid`, with `rx_word` equal to the first WORD_W bits received. During the extra clocks, `spi_miso` keeps driving bit 0 of `tx_word`.
- R7: `frame_err` pulses for one cycle after `spi_csn` rises whenever the number of sample edges is not a multiple of WORD_W. A transfer shorter than WORD_W bits also produces no `rx_valid`. Zero sample edges is not an error.
- R8: With `cfg_chain`=1, bits WORD_W+1 to 2·WORD_W on `spi_miso` repeat bits 1 to WORD_W received on `spi_mosi`. At release, if the bit count is a nonzero multiple of WORD_W, `rx_valid` pulses and `rx_word` holds the last WORD_W bits received.
- R9: `tx_word` is taken once, at select assertion. Changing it during a transfer does not alter the bits on `spi_miso`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_cpol | input | 1 | Idle level of the serial clock |
| cfg_cpha | input | 1 | 0: sample on leading edge; 1: sample on trailing edge |
| cfg_chain | input | 1 | 1: daisy-chain stage, shift register never freezes |
| cfg_strict | input | 1 | Overlength policy: 1 discard, 0 keep first word |
| spi_sclk | input | 1 | Serial clock from the master (asynchronous) |
| spi_mosi | input | 1 | Serial data from the master (asynchronous) |
| spi_csn | input | 1 | Active-low select (asynchronous) |
| spi_miso | output | 1 | Serial data to the master, 0 while not driven |
| spi_miso_oe | output | 1 | Output enable for `spi_miso`; 0 models high impedance |
| tx_word | input | WORD_W | Word to send, taken at select assertion |
| rx_word | output | WORD_W | Last accepted received word |
| rx_valid | output | 1 | One-cycle strobe when `rx_word` is updated |
| sel_start | output | 1 | One-cycle pulse on select assertion |
| frame_err | output | 1 | One-cycle pulse when a frame ends mid-word |

## Verification
The bench runs all four clock modes, because a design that swaps the leading and trailing edge roles would return every word shifted by one bit. It sends overlength frames under both policies. A design that ignores the policy would either accept a word it should drop, or keep shifting and return the tail of the frame instead of its head with the wrong bit held on the output. Short and zero-length frames separate a bad bit count from a good one through the error pulse. Chain-mode frames and a `tx_word` change in mid-frame catch a shift register that freezes too early or that reloads the transmit word after the start.

// File: rtl/spi_chain_pkg.sv
`timescale 1ns/1ps
// Package: shared event record passed from edge detection to the shift core.
package spi_chain_pkg;

    // Per-cycle serial events in the system clock domain.
    typedef struct packed {
        logic selected;  // select line currently active (low)
        logic start;     // select just asserted
        logic stop;      // select just released
        logic sample;    // capture edge of the serial clock while selected
        logic launch;    // output-change edge of the serial clock while selected
    } spi_evt_t;

endpackage

// File: rtl/spi_in_sync.sv
`timescale 1ns/1ps
// Module: spi_in_sync
// Multi-stage synchronizer for a bundle of independent asynchronous bits.
// Assumes each bit is sampled on its own (no multi-bit coherence needed)
// and that inputs stay stable for several destination clock cycles.
module spi_in_sync #(
    parameter int                 WIDTH   = 1,
    parameter int                 STAGES  = 2,
    parameter logic [WIDTH-1:0]   RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] stage_q [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                // First flop: captures the raw asynchronous input.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[g] <= RST_VAL;
                    else        stage_q[g] <= d;
                end
            end else begin : g_next
                // Later flops: give metastability time to settle.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[g] <= RST_VAL;
                    else        stage_q[g] <= stage_q[g-1];
                end
            end
        end
    endgenerate

    assign q = stage_q[STAGES-1];

endmodule

// File: rtl/spi_edge_detect.sv
`timescale 1ns/1ps
// Module: spi_edge_detect
// Turns synchronized serial clock and select levels into one-cycle events.
// The leading edge is the transition away from the idle level set by cpol.
// cpha picks whether sampling happens on the leading or trailing edge, and
// launching happens on the other. Clock edges are masked while deselected.
module spi_edge_detect
    import spi_chain_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     cpol,
    input  logic     cpha,
    input  logic     sclk_s,
    input  logic     csn_s,
    output spi_evt_t evt
);

    logic sclk_d;
    logic csn_d;
    logic clk_edge;
    logic lead_edge;
    logic trail_edge;

    // Keep the previous synchronized levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_d <= 1'b0;
            csn_d  <= 1'b1;
        end else begin
            sclk_d <= sclk_s;
            csn_d  <= csn_s;
        end
    end

    // Classify each serial clock transition and the select transitions.
    always_comb begin
        clk_edge     = sclk_s ^ sclk_d;
        lead_edge    = clk_edge & (sclk_s ^ cpol);
        trail_edge   = clk_edge & ~(sclk_s ^ cpol);
        evt.selected = ~csn_s;
        evt.start    = csn_d & ~csn_s;
        evt.stop     = ~csn_d & csn_s;
        evt.sample   = ~csn_s & (cpha ? trail_edge : lead_edge);
        evt.launch   = ~csn_s & (cpha ? lead_edge : trail_edge);
    end

endmodule

// File: rtl/spi_shift_core.sv
`timescale 1ns/1ps
// Module: spi_shift_core
// One shift register carries both directions: it is loaded with the transmit
// word at select assertion, shifts received bits in at sample edges, and its
// top bit is copied to the output register at launch edges.
// Bits are counted modulo WORD_W, with a saturating count of whole words.
// Outside chain mode, shifting and launching stop after the first word.
// The received word is handed over when select is released.
// Assumes WORD_W >= 2 and that sample and launch never occur in one cycle.
module spi_shift_core
    import spi_chain_pkg::*;
#(
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_chain,
    input  logic              cfg_strict,
    input  spi_evt_t          evt,
    input  logic              mosi_s,
    input  logic [WORD_W-1:0] tx_word,
    output logic              miso_q,
    output logic [WORD_W-1:0] rx_word,
    output logic              rx_valid,
    output logic              sel_start,
    output logic              frame_err
);

    localparam int          POS_W    = (WORD_W > 2) ? $clog2(WORD_W) : 1;
    localparam logic [POS_W-1:0] POS_LAST = POS_W'(WORD_W - 1);
    localparam logic [1:0]  WORDS_MAX = 2'd2;

    logic [WORD_W-1:0] shreg;
    logic [POS_W-1:0]  pos;
    logic [1:0]        words;
    logic              active;
    logic              take;

    // Shifting stays enabled in chain mode, otherwise only for the first word.
    always_comb begin
        active = cfg_chain | (words == 2'd0);
    end

    // Decide at release whether the received word is accepted.
    always_comb begin
        if (cfg_chain)       take = (pos == '0) && (words != 2'd0);
        else if (cfg_strict) take = (pos == '0) && (words == 2'd1);
        else                 take = (words != 2'd0);
    end

    // Shift register, output bit and bit counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg  <= '0;
            miso_q <= 1'b0;
            pos    <= '0;
            words  <= 2'd0;
        end else if (evt.start) begin
            shreg  <= tx_word;
            miso_q <= tx_word[WORD_W-1];
            pos    <= '0;
            words  <= 2'd0;
        end else if (evt.selected) begin
            if (evt.sample) begin
                pos <= (pos == POS_LAST) ? '0 : pos + POS_W'(1);
                if ((pos == POS_LAST) && (words != WORDS_MAX)) words <= words + 2'd1;
                if (active) shreg <= {shreg[WORD_W-2:0], mosi_s};
            end
            if (evt.launch && active) miso_q <= shreg[WORD_W-1];
        end
    end

    // Release handling: hand over the word and report a partial final word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_word   <= '0;
            rx_valid  <= 1'b0;
            frame_err <= 1'b0;
        end else begin
            rx_valid  <= 1'b0;
            frame_err <= 1'b0;
            if (evt.stop) begin
                frame_err <= (pos != '0);
                if (take) begin
                    rx_valid <= 1'b1;
                    rx_word  <= shreg;
                end
            end
        end
    end

    // One-cycle notification of select assertion.
    always_ff @(posedge clk) begin
        if (!rst_n) sel_start <= 1'b0;
        else        sel_start <= evt.start;
    end

endmodule

// File: rtl/spi_chain_slave.sv
`timescale 1ns/1ps
// Module: spi_chain_slave (top)
// Serial target with full-duplex word exchange and an optional daisy-chain
// mode. Pins are synchronized into clk, and edges are found there, so clk must
// be at least four times the serial clock. The output enable follows the
// synchronized select. The data output is forced low while not enabled.
module spi_chain_slave
    import spi_chain_pkg::*;
#(
    parameter int WORD_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_cpol,
    input  logic              cfg_cpha,
    input  logic              cfg_chain,
    input  logic              cfg_strict,
    input  logic              spi_sclk,
    input  logic              spi_mosi,
    input  logic              spi_csn,
    output logic              spi_miso,
    output logic              spi_miso_oe,
    input  logic [WORD_W-1:0] tx_word,
    output logic [WORD_W-1:0] rx_word,
    output logic              rx_valid,
    output logic              sel_start,
    output logic              frame_err
);

    localparam int PIN_N = 3;
    localparam logic [PIN_N-1:0] PIN_RST = 3'b100;  // {csn, mosi, sclk}

    logic [PIN_N-1:0] pins_s;
    logic             sclk_s;
    logic             mosi_s;
    logic             csn_s;
    logic             miso_q;
    spi_evt_t         evt;

    spi_in_sync #(
        .WIDTH   (PIN_N),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (PIN_RST)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({spi_csn, spi_mosi, spi_sclk}),
        .q     (pins_s)
    );

    // Split the synchronized pin bundle.
    always_comb begin
        sclk_s = pins_s[0];
        mosi_s = pins_s[1];
        csn_s  = pins_s[2];
    end

    spi_edge_detect u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .cpol   (cfg_cpol),
        .cpha   (cfg_cpha),
        .sclk_s (sclk_s),
        .csn_s  (csn_s),
        .evt    (evt)
    );

    spi_shift_core #(
        .WORD_W (WORD_W)
    ) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_chain  (cfg_chain),
        .cfg_strict (cfg_strict),
        .evt        (evt),
        .mosi_s     (mosi_s),
        .tx_word    (tx_word),
        .miso_q     (miso_q),
        .rx_word    (rx_word),
        .rx_valid   (rx_valid),
        .sel_start  (sel_start),
        .frame_err  (frame_err)
    );

    // Drive the pad model: enabled only while selected, low otherwise.
    always_comb begin
        spi_miso_oe = evt.selected;
        spi_miso    = evt.selected & miso_q;
    end

endmodule

// File: rtl/spi_chain_slave_chk.sv
`timescale 1ns/1ps
// Module: spi_chain_slave_chk
// Port-level protocol checks, bound to every spi_chain_slave instance.
module spi_chain_slave_chk #(
    parameter int WORD_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              spi_csn,
    input logic              spi_miso,
    input logic              spi_miso_oe,
    input logic [WORD_W-1:0] rx_word,
    input logic              rx_valid,
    input logic              sel_start,
    input logic              frame_err
);

    AST_OE_OFF_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(spi_csn, 2) === 1'b1) |-> !spi_miso_oe);  // R1
    AST_MISO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !spi_miso_oe |-> !spi_miso);  // R1
    AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        sel_start |=> !sel_start);  // R3
    AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);  // R4
    AST_RXWORD_ONLY_ON_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rx_word) |-> rx_valid);  // R4
    AST_VALID_AFTER_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> !spi_miso_oe);  // R4
    AST_FERR_AFTER_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err |-> !spi_miso_oe);  // R7
    AST_FERR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err |=> !frame_err);  // R7

endmodule

bind spi_chain_slave spi_chain_slave_chk #(.WORD_W(WORD_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .spi_csn     (spi_csn),
    .spi_miso    (spi_miso),
    .spi_miso_oe (spi_miso_oe),
    .rx_word     (rx_word),
    .rx_valid    (rx_valid),
    .sel_start   (sel_start),
    .frame_err   (frame_err)
);

// File: tb/tb_spi_chain_slave.sv
`timescale 1ns/1ps
// Directed bench: one task per scenario, each checking its own results.
module tb_spi_chain_slave;

    localparam int W  = 8;
    localparam int HP = 6;  // serial half period in system clocks

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cfg_cpol = 1'b0, cfg_cpha = 1'b0, cfg_chain = 1'b0, cfg_strict = 1'b0;
    logic         spi_sclk = 1'b0, spi_mosi = 1'b0, spi_csn = 1'b1;
    logic         spi_miso, spi_miso_oe;
    logic [W-1:0] tx_word = '0;
    logic [W-1:0] rx_word;
    logic         rx_valid, sel_start, frame_err;

    int n_cmp = 0, n_bad = 0;
    int n_start = 0, n_valid = 0, n_ferr = 0;
    logic [31:0] rec;
    logic        done = 1'b0;

    always #2 clk = ~clk;  // 250 MHz

    spi_chain_slave #(.WORD_W(W)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha),
        .cfg_chain(cfg_chain), .cfg_strict(cfg_strict), .spi_sclk(spi_sclk),
        .spi_mosi(spi_mosi), .spi_csn(spi_csn), .spi_miso(spi_miso),
        .spi_miso_oe(spi_miso_oe), .tx_word(tx_word), .rx_word(rx_word),
        .rx_valid(rx_valid), .sel_start(sel_start), .frame_err(frame_err)
    );

    // Count high cycles of each pulse output.
    always @(posedge clk) begin
        if (rst_n) begin
            if (sel_start) n_start++;
            if (rx_valid)  n_valid++;
            if (frame_err) n_ferr++;
        end
    end

    task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int k);
        repeat (k) @(negedge clk);
    endtask

    // One framed transfer of nb bits, MSB of data first; MISO bits land in rec.
    task automatic xfer(input logic [31:0] data, input int nb, input logic [W-1:0] tx,
                        input logic late, input logic [W-1:0] tx_late);
        rec = '0;
        tx_word  = tx;
        spi_sclk = cfg_cpol;
        tick(4);
        spi_csn = 1'b0;
        for (int i = 0; i < nb; i++) begin
            if (!cfg_cpha) begin
                spi_mosi = data[nb-1-i];
                tick(HP);
                rec[nb-1-i] = spi_miso;
                spi_sclk = ~cfg_cpol;
                tick(HP);
                spi_sclk = cfg_cpol;
            end else begin
                spi_sclk = ~cfg_cpol;
                spi_mosi = data[nb-1-i];
                tick(HP);
                rec[nb-1-i] = spi_miso;
                spi_sclk = cfg_cpol;
                tick(HP);
            end
            if (late && i == 2) tx_word = tx_late;
        end
        tick(HP);
        spi_csn = 1'b1;
        tick(8);
    endtask

    task automatic t_reset;
        chk(spi_miso_oe == 1'b0, "R1 reset oe", 32'(spi_miso_oe), 0);
        chk(spi_miso == 1'b0,    "R1 reset miso", 32'(spi_miso), 0);
        chk(rx_word == '0 && !rx_valid && !sel_start && !frame_err, "R4 reset outputs",
            32'(rx_word), 0);
    endtask

    task automatic t_deselected;
        int s0 = n_start, v0 = n_valid, f0 = n_ferr;
        logic bad = 1'b0;
        spi_csn = 1'b1;
        for (int i = 0; i < 20; i++) begin
            spi_sclk = ~spi_sclk;
            spi_mosi = i[1];
            tick(HP);
            if (spi_miso_oe || spi_miso) bad = 1'b1;
        end
        spi_sclk = 1'b0;
        tick(8);
        chk(!bad, "R1 no drive while deselected", 32'(bad), 0);
        chk(n_start == s0 && n_valid == v0 && n_ferr == f0, "R1 no pulses while deselected",
            32'(n_start - s0 + n_valid - v0 + n_ferr - f0), 0);
    endtask

    task automatic t_mode(input logic pol, input logic pha, input logic [7:0] tx, input logic [7:0] rx);
        int s0 = n_start, v0 = n_valid, f0 = n_ferr;
        cfg_cpol = pol; cfg_cpha = pha; cfg_chain = 1'b0; cfg_strict = 1'b1;
        xfer({24'h0, rx}, 8, tx, 1'b0, '0);
        chk(rec[7:0] == tx, "R2 miso bits", rec, 32'(tx));
        chk(rx_word == rx,  "R2 rx word", 32'(rx_word), 32'(rx));
        chk(n_valid == v0 + 1, "R4 one valid", n_valid - v0, 1);
        chk(n_start == s0 + 1, "R3 one start", n_start - s0, 1);
        chk(n_ferr == f0, "R7 no error on exact frame", n_ferr - f0, 0);
    endtask

    task automatic t_strict_over;
        int v0 = n_valid, f0 = n_ferr;
        logic [W-1:0] keep = rx_word;
        cfg_cpol = 1'b0; cfg_cpha = 1'b0; cfg_chain = 1'b0; cfg_strict = 1'b1;
        xfer(32'h0000_1234, 16, 8'h77, 1'b0, '0);
        chk(n_valid == v0 && rx_word == keep, "R5 16-bit frame dropped", 32'(rx_word), 32'(keep));
        chk(n_ferr == f0, "R7 16-bit frame no error", n_ferr - f0, 0);
        xfer(32'h0000_02F1, 10, 8'h77, 1'b0, '0);
        chk(n_valid == v0 && rx_word == keep, "R5 10-bit frame dropped", 32'(rx_word), 32'(keep));
        chk(n_ferr == f0 + 1, "R7 10-bit frame error", n_ferr - f0, 1);
    endtask

    task automatic t_lenient_over;
        int v0 = n_valid, f0 = n_ferr;
        cfg_cpol = 1'b1; cfg_cpha = 1'b1; cfg_chain = 1'b0; cfg_strict = 1'b0;
        xfer({21'h0, 8'hC3, 3'b010}, 11, 8'h81, 1'b0, '0);
        chk(rx_word == 8'hC3 && n_valid == v0 + 1, "R6 first word kept", 32'(rx_word), 32'hC3);
        chk(rec[10:0] == {8'h81, 3'b111}, "R6 last tx bit held", rec, 32'h40F);
        chk(n_ferr == f0 + 1, "R7 11-bit frame error", n_ferr - f0, 1);
    endtask

    task automatic t_short;
        int v0 = n_valid, f0 = n_ferr, s0 = n_start;
        logic [W-1:0] keep = rx_word;
        cfg_cpol = 1'b0; cfg_cpha = 1'b1; cfg_chain = 1'b0; cfg_strict = 1'b0;
        xfer(32'h15, 5, 8'h3C, 1'b0, '0);
        chk(n_valid == v0 && rx_word == keep, "R7 short frame no valid", 32'(rx_word), 32'(keep));
        chk(n_ferr == f0 + 1, "R7 short frame error", n_ferr - f0, 1);
        f0 = n_ferr;
        xfer(32'h0, 0, 8'h3C, 1'b0, '0);
        chk(n_start == s0 + 2, "R3 start without clocks", n_start - s0, 2);
        chk(n_ferr == f0 && n_valid == v0, "R7 empty frame silent", n_ferr - f0, 0);
    endtask

    task automatic t_chain(input logic pol, input logic pha);
        int v0 = n_valid, f0 = n_ferr;
        cfg_cpol = pol; cfg_cpha = pha; cfg_chain = 1'b1; cfg_strict = 1'b1;
        xfer(32'h0000_6E29, 16, 8'hB4, 1'b0, '0);
        chk(rec[15:8] == 8'hB4, "R8 first group is tx word", rec, 32'hB400);
        chk(rec[7:0] == 8'h6E, "R8 second group copies input", rec, 32'h6E);
        chk(rx_word == 8'h29 && n_valid == v0 + 1, "R8 last word captured", 32'(rx_word), 32'h29);
        chk(n_ferr == f0, "R8 chain frame no error", n_ferr - f0, 0);
    endtask

    task automatic t_tx_late;
        cfg_cpol = 1'b0; cfg_cpha = 1'b0; cfg_chain = 1'b0; cfg_strict = 1'b1;
        xfer(32'h5A, 8, 8'hE7, 1'b1, 8'h18);
        chk(rec[7:0] == 8'hE7, "R9 tx taken at select", rec, 32'hE7);
    endtask

    initial begin
        tick(5);
        rst_n = 1'b1;
        tick(3);
        t_reset();
        t_deselected();
        t_mode(1'b0, 1'b0, 8'hA5, 8'h3C);
        t_mode(1'b0, 1'b1, 8'h96, 8'hD2);
        t_mode(1'b1, 1'b0, 8'h1E, 8'h81);
        t_mode(1'b1, 1'b1, 8'hF0, 8'h4B);
        t_strict_over();
        t_lenient_over();
        t_short();
        t_chain(1'b0, 1'b0);
        t_chain(1'b1, 1'b1);
        t_tx_late();
        t_deselected();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // Watchdog: a hung run is a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule